// File: doc/BRIEF.md
# I2C Wiper Register Bank

This block is an I2C target that holds four 8-bit wiper settings. A bus master can write any one of them and can read them back one after another. SCL and SDA are sampled with a faster system clock. Each line passes through a two-flop synchronizer and then a persistence filter, and bus events are taken from the filtered levels. The block never drives SDA high. It only asserts a pull-low enable for an external open-drain pad. The four settings are presented side by side on a parallel output bus for the logic that consumes them.

A transfer opens with an identification byte. That byte holds a fixed five-bit prefix, the two strap levels and a direction bit. For a write, the master sends an index byte and then a single value byte. For a read, the master sends an index byte, then a repeated START and an identification byte with the read bit set. The block then streams settings from an internal pointer, which steps forward after each byte and wraps. After reset and for a short settling interval, the block ignores all bus activity.

Top module: `i2c_wiper_bank`

## Requirements
- R1: After reset, every wiper output reads 80h and the SDA pull-low enable is deasserted.
- R2: The identification byte is accepted only when bits 7:3 equal 01010b and bits 2:1 equal strap_i[1:0]. Bit 0 selects the direction: 1 means read and 0 means write. Any other byte gets no acknowledge, and the block then ignores the bus until the next START or STOP.
- R3: An index byte of 00h to 03h selects wiper 0 to 3 and is acknowledged. An index byte above 03h gets no acknowledge and changes no wiper.
- R4: In a write, the block pulls SDA low during the ninth clock after the identification byte, after the index byte and after the value byte. The selected wiper takes the value when the eighth value bit completes, before the acknowledge clock rises. No further byte of the same transfer is acknowledged.
- R5: In a read, the block sends the selected wiper MSB first and then advances the pointer by one per byte. The pointer wraps from 3 to 0, and bytes continue for as long as the master acknowledges.
- R6: When the master does not acknowledge a read byte, the block releases SDA and drives nothing more until a START or a STOP.
- R7: A STOP or START that arrives before all eight value bits have been received leaves every wiper unchanged. A START always restarts identification-byte reception.
- R8: Pulses on SCL or SDA shorter than FILT_CYC system clocks (60 ns by default) are never taken as clock edges, STARTs or STOPs.
- R9: A START detected during the first PWRUP_CYC clocks after reset is ignored.
- R10: The pull-low enable only ever asserts while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level from the pad |
| sda_i | input | 1 | Bus data level from the pad |
| strap_i | input | 2 | Strap levels compared with identification bits 2:1 |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| wiper_o | output | NREG*DW (32) | Wiper settings; wiper k is on bits k*8+7 to k*8 |

## Verification
A corrupted pointer or state shows up at the ports within one byte. Either a read returns the wrong setting, or an acknowledge arrives that should not (or fails to arrive) on the ninth clock that follows. A write that is taken in error, or taken at the wrong moment, shows on wiper_o within a few clocks. The bench compares wiper_o with its own model on every clock, outside a short window around each legitimate acknowledge. A filter or edge detector that passes a glitch appears as an acknowledge to a byte that had no START before it.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_ID, ST_ID_ACK, ST_ADDR, ST_ADDR_ACK,
    ST_DATA, ST_DATA_ACK, ST_TX, ST_TX_ACK, ST_WAIT
  } bus_state_e;
endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int STAGES   = 2,
  parameter int FILT_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int CW = $clog2(FILT_CYC + 1);

  logic [STAGES-1:0] sync_q;
  logic              filt_q, filt_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              s;

  assign s = sync_q[STAGES-1];

  always_comb begin
    filt_n = filt_q;
    cnt_n  = '0;
    if (s != filt_q) begin
      if (cnt_q == CW'(FILT_CYC - 1)) filt_n = s;
      else                            cnt_n  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], raw_i};
      filt_q <= filt_n;
      cnt_q  <= cnt_n;
    end
  end

  assign filt_o = filt_q;

  // R8: the filtered level only moves to a level the synchronizer has held
  p_filter_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(s)));
endmodule

// File: rtl/wiper_regs.sv
module wiper_regs #(
  parameter int NREG  = 4,
  parameter int DW    = 8,
  parameter int AW    = 2,
  parameter logic [DW-1:0] RST_VAL = 8'h80
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [AW-1:0]      waddr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [NREG*DW-1:0] q_o
);
  for (genvar k = 0; k < NREG; k++) begin : g_reg
    logic [DW-1:0] r_q;
    logic          en;
    assign en = we_i && (waddr_i == AW'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  r_q <= RST_VAL;
      else if (en) r_q <= wdata_i;
    end
    assign q_o[k*DW +: DW] = r_q;
  end

  // R7: no wiper moves unless a completed value byte was handed over
  p_hold_without_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(we_i) |-> $stable(q_o));
endmodule

// File: rtl/bus_fsm.sv
module bus_fsm
  import wiper_pkg::*;
#(
  parameter int NREG = 4,
  parameter int DW   = 8,
  parameter int AW   = 2,
  parameter logic [4:0] ID_PREFIX = 5'b01010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          sda_f_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [1:0]    strap_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] ptr_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic          pull_o
);
  localparam int CW = $clog2(DW + 1);

  bus_state_e    st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [DW-1:0] sh_q, sh_n;
  logic [AW-1:0] ptr_q, ptr_n, ptr_inc;
  logic          rd_q, rd_n, ack_q, ack_n;

  assign ptr_inc = (ptr_q == AW'(NREG - 1)) ? '0 : ptr_q + 1'b1;

  always_comb begin
    st_n = st_q; cnt_n = cnt_q; sh_n = sh_q; ptr_n = ptr_q;
    rd_n = rd_q; ack_n = ack_q; we_o = 1'b0;
    if (busy_i) begin
      st_n = ST_IDLE;
    end else if (start_i) begin
      st_n = ST_ID; cnt_n = '0;
    end else if (stop_i) begin
      st_n = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_ID, ST_ADDR, ST_DATA: begin
          if (scl_rise_i && cnt_q != CW'(DW)) begin
            sh_n  = {sh_q[DW-2:0], sda_f_i};
            cnt_n = cnt_q + 1'b1;
          end
          if (scl_fall_i && cnt_q == CW'(DW)) begin
            cnt_n = '0;
            st_n  = ST_WAIT;
            if (st_q == ST_ID) begin
              if (sh_q[7:3] == ID_PREFIX && sh_q[2:1] == strap_i) begin
                rd_n = sh_q[0]; st_n = ST_ID_ACK;
              end
            end else if (st_q == ST_ADDR) begin
              if (sh_q < DW'(NREG)) begin
                ptr_n = sh_q[AW-1:0]; st_n = ST_ADDR_ACK;
              end
            end else begin
              we_o = 1'b1; st_n = ST_DATA_ACK;
            end
          end
        end
        ST_ID_ACK: if (scl_fall_i) begin
          if (rd_q) begin
            sh_n = rdata_i; ptr_n = ptr_inc; cnt_n = '0; st_n = ST_TX;
          end else st_n = ST_ADDR;
        end
        ST_ADDR_ACK: if (scl_fall_i) st_n = ST_DATA;
        ST_DATA_ACK: if (scl_fall_i) st_n = ST_WAIT;
        ST_TX: begin
          if (scl_rise_i) cnt_n = cnt_q + 1'b1;
          if (scl_fall_i) begin
            if (cnt_q == CW'(DW)) begin cnt_n = '0; st_n = ST_TX_ACK; end
            else sh_n = {sh_q[DW-2:0], 1'b1};
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) ack_n = !sda_f_i;
          if (scl_fall_i) begin
            if (ack_q) begin
              sh_n = rdata_i; ptr_n = ptr_inc; cnt_n = '0; st_n = ST_TX;
            end else st_n = ST_WAIT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; sh_q <= '0; ptr_q <= '0;
      rd_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      st_q <= st_n; cnt_q <= cnt_n; sh_q <= sh_n; ptr_q <= ptr_n;
      rd_q <= rd_n; ack_q <= ack_n;
    end
  end

  assign ptr_o   = ptr_q;
  assign wdata_o = sh_q;
  assign pull_o  = (st_q == ST_ID_ACK) || (st_q == ST_ADDR_ACK) ||
                   (st_q == ST_DATA_ACK) || (st_q == ST_TX && !sh_q[DW-1]);

  // R9: nothing leaves idle while the power-up interval runs
  p_idle_in_pwrup_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> (st_q == ST_IDLE));
  // R4: a handed-over value is always followed by the acknowledge clock
  p_write_then_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |=> (st_q == ST_DATA_ACK && pull_o));
  // R6: the master acknowledge clock is never driven by this block
  p_release_master_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TX_ACK || st_q == ST_WAIT) |-> !pull_o);
endmodule

// File: rtl/i2c_wiper_bank.sv
module i2c_wiper_bank #(
  parameter int NREG      = 4,
  parameter int DW        = 8,
  parameter int FILT_CYC  = 6,
  parameter int PWRUP_CYC = 128
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [1:0]         strap_i,
  output logic               sda_pull_o,
  output logic [NREG*DW-1:0] wiper_o
);
  localparam int AW  = $clog2(NREG);
  localparam int PCW = $clog2(PWRUP_CYC + 1);

  logic [1:0]    rst_sync_q;
  logic          rst_i_n;
  logic          scl_f, sda_f, scl_q, sda_q;
  logic          scl_rise, scl_fall, start_det, stop_det;
  logic [PCW-1:0] pw_q;
  logic          busy;
  logic [AW-1:0] ptr;
  logic          we;
  logic [DW-1:0] wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  line_filter #(.STAGES(2), .FILT_CYC(FILT_CYC)) u_scl_filt (
    .clk(clk), .rst_n(rst_i_n), .raw_i(scl_i), .filt_o(scl_f));
  line_filter #(.STAGES(2), .FILT_CYC(FILT_CYC)) u_sda_filt (
    .clk(clk), .rst_n(rst_i_n), .raw_i(sda_i), .filt_o(sda_f));

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; pw_q <= '0;
    end else begin
      scl_q <= scl_f; sda_q <= sda_f;
      if (busy) pw_q <= pw_q + 1'b1;
    end
  end

  assign busy      = (pw_q != PCW'(PWRUP_CYC));
  assign scl_rise  = scl_f && !scl_q;
  assign scl_fall  = !scl_f && scl_q;
  assign start_det = scl_q && scl_f && sda_q && !sda_f;
  assign stop_det  = scl_q && scl_f && !sda_q && sda_f;

  bus_fsm #(.NREG(NREG), .DW(DW), .AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_i_n), .busy_i(busy), .sda_f_i(sda_f),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .strap_i(strap_i),
    .rdata_i(wiper_o[ptr*DW +: DW]), .ptr_o(ptr), .we_o(we),
    .wdata_o(wdata), .pull_o(sda_pull_o));

  wiper_regs #(.NREG(NREG), .DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .we_i(we), .waddr_i(ptr),
    .wdata_i(wdata), .q_o(wiper_o));

  // R10: the pull-low enable only turns on while the bus clock is low
  p_pull_rise_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_i_n)
    (sda_pull_o && !$past(sda_pull_o)) |-> !scl_f);
endmodule

// File: tb/test_i2c_wiper_bank.sv
module test_i2c_wiper_bank;
  localparam int Q = 25;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1, sda_m = 1'b1;
  logic [1:0]  strap = 2'b10;
  logic        pull;
  logic [31:0] wiper;
  logic        line;
  logic [7:0]  model [4];
  bit          settle = 1'b1;
  int          checks = 0, errors = 0;

  assign line = sda_m & ~pull;

  i2c_wiper_bank i_i2c_wiper_bank (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(line),
    .strap_i(strap), .sda_pull_o(pull), .wiper_o(wiper));

  always #5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // reference comparison of the wiper bus on every clock
  always @(negedge clk) begin
    if (!settle) begin
      for (int k = 0; k < 4; k++) chk("R7 wiper model", wiper[k*8 +: 8], model[k]);
    end
  end

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(output bit s1, output bit s2);
    wq(Q); scl = 1'b1; wq(Q); s1 = line; wq(Q - 1); s2 = line; wq(1);
    scl = 1'b0; wq(2);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(2);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(logic [7:0] b, int n);
    bit a, c;
    for (int i = 7; i > 7 - n; i--) begin sda_m = b[i]; pulse(a, c); end
  endtask

  task automatic send_byte(logic [7:0] b, output bit ack);
    bit a, c;
    send_bits(b, 8);
    sda_m = 1'b1; pulse(a, c); ack = !a;
  endtask

  task automatic recv_byte(bit mack, output logic [7:0] b);
    bit a, c;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; pulse(a, c); b[i] = a;
      chk("R10 data stable while SCL high", c, a);
    end
    sda_m = !mack; pulse(a, c); sda_m = 1'b1;
  endtask

  task automatic write_reg(logic [7:0] id, logic [7:0] idx, logic [7:0] d,
                           output bit a1, output bit a2, output bit a3);
    start_c(); send_byte(id, a1); send_byte(idx, a2);
    settle = 1'b1; send_byte(d, a3);
    if (a1 && a2 && a3 && idx < 4) model[idx[1:0]] = d;
    settle = 1'b0; stop_c();
  endtask

  initial begin
    bit a1, a2, a3;
    logic [7:0] b;
    for (int k = 0; k < 4; k++) model[k] = 8'h80;
    wq(4); rst_n = 1'b1; wq(4);
    chk("R1 pull released after reset", pull, 0);
    for (int k = 0; k < 4; k++) chk("R1 wiper reset value", wiper[k*8 +: 8], 8'h80);
    settle = 1'b0;

    // R9: START inside the power-up interval
    start_c(); send_byte(8'h54, a1); chk("R9 START during power-up ignored", a1, 0);
    stop_c(); wq(200);

    // R4: full write with three acknowledges
    write_reg(8'h54, 8'h01, 8'h3C, a1, a2, a3);
    chk("R4 ack id", a1, 1); chk("R4 ack index", a2, 1); chk("R4 ack value", a3, 1);
    chk("R4 wiper1 written", wiper[15:8], 8'h3C);

    // R2: wrong strap and wrong prefix
    write_reg(8'h52, 8'h00, 8'h99, a1, a2, a3);
    chk("R2 wrong strap nack", a1, 0); chk("R2 ignored after nack", a3, 0);
    write_reg(8'hD4, 8'h00, 8'h99, a1, a2, a3);
    chk("R2 wrong prefix nack", a1, 0);

    // R3: index out of range
    write_reg(8'h54, 8'h05, 8'h99, a1, a2, a3);
    chk("R3 index 05h nack", a2, 0); chk("R3 value not acked", a3, 0);

    write_reg(8'h54, 8'h00, 8'h11, a1, a2, a3);
    write_reg(8'h54, 8'h02, 8'hA5, a1, a2, a3);
    write_reg(8'h54, 8'h03, 8'hFE, a1, a2, a3);
    chk("R3 wiper3 selected", wiper[31:24], 8'hFE);

    // R5 / R6: sequential read from index 2 with wrap
    start_c(); send_byte(8'h54, a1); send_byte(8'h02, a2);
    start_c(); send_byte(8'h55, a3);
    chk("R5 read id ack", a3, 1);
    recv_byte(1'b1, b); chk("R5 read index2", b, 8'hA5);
    recv_byte(1'b1, b); chk("R5 read index3", b, 8'hFE);
    recv_byte(1'b1, b); chk("R5 wrap to index0", b, 8'h11);
    recv_byte(1'b0, b); chk("R5 read index1", b, 8'h3C);
    wq(Q); chk("R6 released after master nack", pull, 0);
    send_byte(8'h00, a1); chk("R6 no drive after nack", a1, 0);
    stop_c();

    // R7: STOP cuts a value byte short
    start_c(); send_byte(8'h54, a1); send_byte(8'h00, a2);
    send_bits(8'h00, 4); stop_c();
    chk("R7 STOP mid-byte keeps wiper0", wiper[7:0], 8'h11);

    // R7: START mid-byte, then a fresh write
    start_c(); send_byte(8'h54, a1); send_byte(8'h01, a2); send_bits(8'h00, 5);
    start_c(); send_byte(8'h54, a1); chk("R7 START restarts id", a1, 1);
    send_byte(8'h01, a2); settle = 1'b1; send_byte(8'h77, a3);
    model[1] = 8'h77; settle = 1'b0; stop_c();
    chk("R7 wiper1 after restart", wiper[15:8], 8'h77);

    // R8: short SDA glitch while SCL high is not a START
    wq(Q); sda_m = 1'b0; wq(3); sda_m = 1'b1; wq(Q);
    scl = 1'b0; wq(Q); send_byte(8'h54, a1);
    chk("R8 glitch not a START", a1, 0);
    stop_c();

    // R5: single-byte read from index 3
    start_c(); send_byte(8'h54, a1); send_byte(8'h03, a2);
    start_c(); send_byte(8'h55, a3); recv_byte(1'b0, b);
    chk("R5 read index3 single", b, 8'hFE); stop_c();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule